// File: doc/BRIEF.md
# Inter-processor and Timer Interrupt Controller

This block keeps two pending bits for each of up to four processors. One bit is an inter-processor interrupt and the other is an interval-timer interrupt. Each pending bit drives a level output straight to its processor. Software changes the bits through a 64-bit register port that has four registers:

- a control register, whose three four-bit fields can post inter-processor interrupts, clear inter-processor interrupts and clear timer interrupts, all in the same write;
- an inter-processor status register, which is cleared by mask when written;
- a timer status register, which is cleared by mask when written;
- a request register, which posts inter-processor interrupts by mask.

A timer tick input sets the timer bit of every active processor. The interval timer itself is outside this block.

Every access gets a registered response one cycle later. The response carries read data and an error flag. Two warning pulses come out with the response:

- one for an inter-processor request that hits a bit that is already pending;
- one for an inter-processor clear that hits a bit that is not pending.

The parameter `ACTIVE_CPUS` (1 to 4) sets how many processors exist. Mask bits for higher processors have no effect.

Top module: `ipi_timer_irq_ctrl`

## Requirements
- R1: After reset, `ipi_irq`, `tmr_irq`, `rsp_valid`, `rsp_err`, `rsp_rdata`, `warn_dup` and `warn_idle` are all zero.
- R2: A write to the control register (address 0) whose bits 15:12 are nonzero sets the inter-processor pending bit of processor i for each set bit 12+i. `ipi_irq[i]` rises on the clock edge that accepts the write.
- R3: In a control write, bit 8+i clears inter-processor bit i and bit 4+i clears timer bit i. When one write both requests and clears the same inter-processor bit, the clear wins.
- R4: A control write with bit 28 set and bits 15:4 zero is accepted without error and changes no state. A control write with bits 15:4 and bit 28 all zero returns an error.
- R5: Register addresses are decoded as follows:
  - Address 1: a write clears inter-processor bits by the mask in `req_wdata[3:0]`.
  - Address 2: a write clears timer bits by that mask.
  - Address 3: a write sets inter-processor bits by that mask.
  - Reads of addresses 1 and 2 return the pending vector in bits 3:0, with all higher bits zero.
- R6: A write to address 1, 2 or 3 whose mask bits 3:0 are all zero returns an error and changes no state.
- R7: A read of the control register returns `req_cpu` in bits 1:0 and zero elsewhere. A read of address 3 returns zero. Any access to addresses 4 to 7 returns an error with zero data and changes no state.
- R8: A `timer_tick` sets the timer bit of every active processor. A timer clear to the same bit in the same cycle wins over the tick.
- R9: An inter-processor request that targets an active processor whose bit is already pending leaves that bit set and pulses `warn_dup` with the response.
- R10: An inter-processor clear that targets an active processor with no pending bit pulses `warn_idle` with the response.
- R11: Bits for processors numbered `ACTIVE_CPUS` and above are ignored, and their outputs stay zero.
- R12: Every accepted request produces exactly one `rsp_valid` pulse, in the cycle after the request. With no request, `rsp_valid` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register access this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Register index |
| req_wdata | input | DATA_W | Write data |
| req_cpu | input | 2 | Identifier of the requesting processor |
| timer_tick | input | 1 | Interval timer event |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_err | output | 1 | Access rejected |
| rsp_rdata | output | DATA_W | Read data |
| ipi_irq | output | 4 | Inter-processor interrupt level per processor |
| tmr_irq | output | 4 | Timer interrupt level per processor |
| warn_dup | output | 1 | Request hit a bit that was already pending |
| warn_idle | output | 1 | Clear hit a bit that was not pending |

## Verification
All pending state sits directly on `ipi_irq` and `tmr_irq`. A wrong set, clear or priority decision therefore shows at the ports on the very edge that accepts the access, with no delay. A bad field decode shows as well in the error flag or a warning pulse in the following response cycle. A stale or misrouted bit that a level check could miss is caught by the readback of the status registers, which compares the whole vector against the model.

// File: rtl/ipi_timer_irq_ctrl.sv
module ipi_timer_irq_ctrl #(
  parameter int ACTIVE_CPUS = 4,
  parameter int ADDR_W      = 3,
  parameter int DATA_W      = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [1:0]        req_cpu,
  input  logic              timer_tick,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [3:0]        ipi_irq,
  output logic [3:0]        tmr_irq,
  output logic              warn_dup,
  output logic              warn_idle
);
  localparam logic [3:0] ACT = 4'((1 << ACTIVE_CPUS) - 1);
  localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_ICLR = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_TCLR = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_IREQ = ADDR_W'(3);

  logic wr, is_ctl, is_iclr, is_tclr, is_ireq, known, err;
  logic [3:0] set_ipi, clr_ipi, clr_tmr, mask;
  logic [DATA_W-1:0] rdata;

  assign wr      = req_valid & req_write;
  assign is_ctl  = req_addr == A_CTL;
  assign is_iclr = req_addr == A_ICLR;
  assign is_tclr = req_addr == A_TCLR;
  assign is_ireq = req_addr == A_IREQ;
  assign known   = is_ctl | is_iclr | is_tclr | is_ireq;
  assign mask    = req_wdata[3:0];

  assign set_ipi = ACT & ((wr & is_ctl)  ? req_wdata[15:12] :
                          (wr & is_ireq) ? mask : 4'd0);
  assign clr_ipi = ACT & ((wr & is_ctl)  ? req_wdata[11:8] :
                          (wr & is_iclr) ? mask : 4'd0);
  assign clr_tmr = ACT & ((wr & is_ctl)  ? req_wdata[7:4] :
                          (wr & is_tclr) ? mask : 4'd0);

  assign err = req_valid & (~known |
               (req_write & is_ctl & (req_wdata[15:4] == 12'd0) & ~req_wdata[28]) |
               (req_write & ~is_ctl & (mask == 4'd0)));

  always_comb begin
    rdata = '0;
    if (req_valid & ~req_write) begin
      if (is_ctl)       rdata[1:0] = req_cpu;
      else if (is_iclr) rdata[3:0] = ipi_irq;
      else if (is_tclr) rdata[3:0] = tmr_irq;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ipi_irq   <= '0;
      tmr_irq   <= '0;
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
      warn_dup  <= 1'b0;
      warn_idle <= 1'b0;
    end else begin
      ipi_irq   <= (ipi_irq | set_ipi) & ~clr_ipi;
      tmr_irq   <= (tmr_irq | (timer_tick ? ACT : 4'd0)) & ~clr_tmr;
      rsp_valid <= req_valid;
      rsp_err   <= err;
      rsp_rdata <= rdata;
      warn_dup  <= |(set_ipi & ipi_irq);
      warn_idle <= |(clr_ipi & ~ipi_irq);
    end
  end
endmodule

module ipi_timer_irq_ctrl_chk #(
  parameter int ACTIVE_CPUS = 4,
  parameter int ADDR_W      = 3,
  parameter int DATA_W      = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DATA_W-1:0] req_wdata,
  input logic [1:0]        req_cpu,
  input logic              timer_tick,
  input logic              rsp_valid,
  input logic              rsp_err,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic [3:0]        ipi_irq,
  input logic [3:0]        tmr_irq,
  input logic              warn_dup,
  input logic              warn_idle
);
  localparam logic [3:0] ACT = 4'((1 << ACTIVE_CPUS) - 1);

  p_resp_r12: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  p_no_resp_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid && $stable(ipi_irq));
  p_inactive_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ((ipi_irq | tmr_irq) & ~ACT) == 4'd0);
  p_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (timer_tick && !(req_valid && req_write && (req_addr == 0 || req_addr == 2)))
      |=> (tmr_irq & ACT) == ACT);
  p_post_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr == 3)
      |=> (ipi_irq & $past(req_wdata[3:0]) & ACT) == ($past(req_wdata[3:0]) & ACT));
  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr == 1) |=> (ipi_irq & $past(req_wdata[3:0])) == 4'd0);
  p_zero_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr == 3 && req_wdata[3:0] == 4'd0)
      |=> rsp_err && ipi_irq == $past(ipi_irq));
  p_warn_rsp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (warn_dup || warn_idle) |-> rsp_valid);
endmodule

bind ipi_timer_irq_ctrl ipi_timer_irq_ctrl_chk #(
  .ACTIVE_CPUS(ACTIVE_CPUS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/test_ipi_timer_irq_ctrl.sv
module test_ipi_timer_irq_ctrl;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, timer_tick = 0;
  logic [2:0] req_addr = 0;
  logic [63:0] req_wdata = 0;
  logic [1:0] req_cpu = 0;
  logic        v4, e4, d4, i4, v3, e3, d3, i3;
  logic [63:0] r4, r3;
  logic [3:0]  ip4, tm4, ip3, tm3;
  logic [3:0]  m_ip4 = 0, m_tm4 = 0, m_ip3 = 0, m_tm3 = 0;
  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  ipi_timer_irq_ctrl i_ipi_timer_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_cpu(req_cpu), .timer_tick(timer_tick),
    .rsp_valid(v4), .rsp_err(e4), .rsp_rdata(r4), .ipi_irq(ip4), .tmr_irq(tm4),
    .warn_dup(d4), .warn_idle(i4));

  ipi_timer_irq_ctrl #(.ACTIVE_CPUS(3)) i_ipi_timer_irq_ctrl_a3 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_cpu(req_cpu), .timer_tick(timer_tick),
    .rsp_valid(v3), .rsp_err(e3), .rsp_rdata(r3), .ipi_irq(ip3), .tmr_irq(tm3),
    .warn_dup(d3), .warn_idle(i3));

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic void model(input logic [3:0] am, input logic v, input logic w,
      input logic [2:0] a, input logic [63:0] d, input logic [1:0] cpu, input logic tk,
      inout logic [3:0] ip, inout logic [3:0] tm,
      output logic err, output logic wd, output logic wi, output logic [63:0] rd);
    logic [3:0] s, c, ct;
    s = 0; c = 0; ct = 0; err = 0; rd = 0;
    if (v && w) begin
      case (a)
        3'd0: begin s = d[15:12]; c = d[11:8]; ct = d[7:4];
                    err = (d[15:4] == 0) && !d[28]; end
        3'd1: begin c = d[3:0];  err = d[3:0] == 0; end
        3'd2: begin ct = d[3:0]; err = d[3:0] == 0; end
        3'd3: begin s = d[3:0];  err = d[3:0] == 0; end
        default: err = 1;
      endcase
    end else if (v) begin
      case (a)
        3'd0: rd = {62'd0, cpu};
        3'd1: rd = {60'd0, ip};
        3'd2: rd = {60'd0, tm};
        3'd3: rd = 0;
        default: err = 1;
      endcase
    end
    s &= am; c &= am; ct &= am;
    wd = |(s & ip);
    wi = |(c & ~ip);
    ip = (ip | s) & ~c;
    tm = (tm | (tk ? am : 4'd0)) & ~ct;
  endfunction

  task automatic op(string tag, logic v, logic w, logic [2:0] a, logic [63:0] d,
                    logic [1:0] cpu, logic tk);
    logic ee4, wd4, wi4, ee3, wd3, wi3;
    logic [63:0] rd4, rd3;
    req_valid = v; req_write = w; req_addr = a; req_wdata = d; req_cpu = cpu; timer_tick = tk;
    model(4'hF, v, w, a, d, cpu, tk, m_ip4, m_tm4, ee4, wd4, wi4, rd4);
    model(4'h7, v, w, a, d, cpu, tk, m_ip3, m_tm3, ee3, wd3, wi3, rd3);
    @(negedge clk);
    check({tag, " R12 valid"}, 64'(v4), 64'(v));
    check({tag, " R2 ipi"}, 64'(ip4), 64'(m_ip4));
    check({tag, " R8 tmr"}, 64'(tm4), 64'(m_tm4));
    check({tag, " R6 err"}, 64'(e4), 64'(v & ee4));
    check({tag, " R5 rdata"}, r4, rd4);
    check({tag, " R9 dup"}, 64'(d4), 64'(v & wd4));
    check({tag, " R10 idle"}, 64'(i4), 64'(v & wi4));
    check({tag, " R11 ipi3"}, 64'(ip3), 64'(m_ip3));
    check({tag, " R11 tmr3"}, 64'(tm3), 64'(m_tm3));
    check({tag, " R11 dup3"}, 64'(d3), 64'(v & wd3));
    check({tag, " R11 idle3"}, 64'(i3), 64'(v & wi3));
    req_valid = 0; timer_tick = 0;
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    check("R1 ipi", 64'(ip4), 0);
    check("R1 tmr", 64'(tm4), 0);
    check("R1 rsp", {61'd0, v4, e4, d4 | i4}, 0);
    check("R1 rdata", r4, 0);
    op("R2 post all", 1, 1, 0, 64'h0000_F000, 0, 0);
    op("R9 repost", 1, 1, 0, 64'h0000_3000, 0, 0);
    op("R8 tick", 0, 0, 0, 0, 0, 1);
    op("R3 ctl clears", 1, 1, 0, 64'h0000_0330, 0, 0);
    op("R10 clear idle", 1, 1, 0, 64'h0000_0100, 0, 0);
    op("R3 clear wins", 1, 1, 0, 64'h0000_1100, 0, 0);
    op("R4 bit28 only", 1, 1, 0, 64'h1000_0000, 0, 0);
    op("R4 empty ctl", 1, 1, 0, 64'hFFFF_0000_EFFF_000F, 0, 0);
    op("R5 post mask", 1, 1, 3, 64'h5, 0, 0);
    op("R5 read ipi", 1, 0, 1, 0, 0, 0);
    op("R5 read tmr", 1, 0, 2, 0, 0, 0);
    op("R6 zero mask", 1, 1, 1, 64'hF0, 0, 0);
    op("R7 read ctl", 1, 0, 0, 0, 2, 0);
    op("R7 bad addr", 1, 1, 6, 64'hF, 0, 0);
    op("R8 tick vs clear", 1, 1, 2, 64'h9, 0, 1);
    op("R11 cpu3 post", 1, 1, 3, 64'h8, 0, 0);
    for (int n = 0; n < 3000; n++) begin
      logic [63:0] d;
      logic [2:0] a;
      d = {$urandom, $urandom};
      a = 3'($urandom % 6);
      if ($urandom % 3 == 0) d &= 64'h0000_0000_1000_FFFF;
      if ($urandom % 8 == 0) d &= 64'h1000_0000;
      op("R12 random", 1'($urandom % 5 != 0), 1'($urandom % 3 != 0), a, d,
         2'($urandom), 1'($urandom % 6 == 0));
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule